// File: doc/BRIEF.md
# Two-Bank SDRAM Precharge Scheduler

This block sits on the controller side of a synchronous DRAM that has two banks. It keeps an open or closed flag for each bank and decides when a precharge may start. It considers the CAS latency (1, 2 or 3), the burst length and the kind of access: read or write, and auto-precharge or left open. Explicit precharge requests that arrive too early are held. Each is issued on the first legal cycle as a command on the RAS/CAS/WE pins, with a two-bit bank code on A10/A11. A NOP is driven on every other cycle.

Auto-precharge happens inside the memory and puts nothing on the pins. For these accesses the scheduler closes the bank flag on the cycle the internal precharge begins. A power-down request is granted only when both banks are closed and no precharge is outstanding. Entry takes one clock and exit takes one clock. While power-down is granted, the block ignores activate, access and precharge inputs.

Cycle numbering used below: an access is issued in cycle t0, the cycle in which `accValid` is high. Read data leaves the memory in cycles t0+CL to t0+CL+BL-1. Write data enters the memory in cycles t0 to t0+BL-1. A registered output that is decided in cycle c is visible in cycle c+1.

Top module: `bank_precharge_sched`

## Requirements
- R1: After reset, and on every cycle without a precharge, the pins carry a NOP (rasN=1, casN=1, weN=1) with a10=0 and a11=0. After reset, both bank flags and pdGrant are 0.
- R2: A precharge is driven as rasN=0, casN=1, weN=0. The bank code is a10=0,a11=0 for bank 0; a10=0,a11=1 for bank 1; and a10=1,a11=0 for both banks.
- R3: An activate (actValid with actBank) sets bankOpen[actBank] from the next cycle. The flag goes low in the cycle the precharge for that bank starts, whether explicit or automatic.
- R4: A read with auto-precharge closes its bank in cycle t0+BL at every CAS latency. This is one cycle before the last data beat at CL2, two cycles before it at CL3, and on the last beat at CL1. No command appears on the pins for it.
- R5: A write with auto-precharge closes its bank in cycle t0+BL at CL1 or CL2, and in t0+BL+1 at CL3. This is one or two cycles after the last data beat in cycle t0+BL-1.
- R6: After a read without auto-precharge, the earliest explicit precharge is in cycle t0+BL at CL1 or CL2, and in t0+BL+1 at CL3. At CL1 this is the last beat; at CL2 and CL3 it is the second-to-last beat.
- R7: After a write without auto-precharge, the earliest explicit precharge is in cycle t0+BL-1+TWR, that is TWR cycles after the last data beat.
- R8: A precharge request in cycle r is issued in cycle max(r+1, earliest legal cycle). A request made too early is held until then.
- R9: A request with preAll high gives a single all-banks command when both banks are ready. A request to a bank that is already closed is accepted and issued on the next cycle.
- R10: pdGrant rises one cycle after pdReq, but only in a cycle with both banks closed, nothing pending, and no activate, access or precharge input. It falls one cycle after pdReq goes low.
- R11: While pdGrant is high the pins carry NOP, and activate, access and precharge inputs leave no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| actValid | input | 1 | Row activate issued this cycle |
| actBank | input | 1 | Bank of the activate |
| accValid | input | 1 | Read or write issued this cycle (cycle t0) |
| accWrite | input | 1 | 1 = write, 0 = read |
| accBank | input | 1 | Bank of the access |
| accAuto | input | 1 | Access carries auto-precharge (address bit 10 high) |
| casLat | input | 2 | CAS latency, 1 to 3 |
| burstLen | input | BL_W | Burst length in beats, at least 1 |
| preReq | input | 1 | Explicit precharge request |
| preAll | input | 1 | Request targets both banks |
| preBank | input | 1 | Target bank when preAll is low |
| pdReq | input | 1 | Power-down request, held for the whole stay |
| rasN | output | 1 | Row strobe pin, active low |
| casN | output | 1 | Column strobe pin, active low |
| weN | output | 1 | Write enable pin, active low |
| a10 | output | 1 | Bank code bit: all banks |
| a11 | output | 1 | Bank code bit: bank select |
| bankOpen | output | 2 | Per-bank open flag |
| pdGrant | output | 1 | Power-down granted |

## Verification
The assertions assume that an activate only targets a closed bank, and that an access only targets an open bank with no precharge counting down. They also assume that casLat stays in 1 to 3, that burstLen is nonzero, and that both stay stable while a burst is in flight. The bench meets these assumptions as follows. Each scenario activates one bank, issues a single access with random latency, length, direction and auto flag, and then waits for that bank to close before starting the next. Power-down cases are driven only after both banks are closed, except the directed case that tests refusal while a bank is open.

// File: rtl/bank_precharge_pkg.sv
package bank_precharge_pkg;
  localparam int NUM_BANKS = 2;

  // Issue strobes from control to the pin datapath.
  typedef struct packed {
    logic fireB;
    logic fireA;
  } sched_strobe_t;
endpackage

// File: rtl/bank_precharge_dp.sv
module bank_precharge_dp
  import bank_precharge_pkg::*;
#(
  parameter int BL_W = 4,
  parameter int TWR  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accWrite,
  input  logic                 accAuto,
  input  logic [1:0]           casLat,
  input  logic [BL_W-1:0]      burstLen,
  input  logic [NUM_BANKS-1:0] loadMask,
  input  sched_strobe_t        strobe,
  output logic [NUM_BANKS-1:0] ready,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic                 a10,
  output logic                 a11
);
  localparam int CNT_W = $clog2((1 << BL_W) + TWR + 2);

  logic [CNT_W-1:0] blExt;
  logic [CNT_W-1:0] cl3;
  logic [CNT_W-1:0] dNow;

  // Cycles from the access to its first legal precharge cycle
  always_comb begin
    blExt = CNT_W'(burstLen);
    cl3   = CNT_W'(casLat == 2'd3);
    if (!accWrite) dNow = accAuto ? blExt : blExt + cl3;
    else           dNow = accAuto ? blExt + cl3 : blExt + CNT_W'(TWR) - CNT_W'(1);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] holdCnt;
    always_ff @(posedge clk) begin
      if (!rstN)                  holdCnt <= '0;
      else if (loadMask[b])       holdCnt <= dNow - CNT_W'(1);
      else if (holdCnt != '0)     holdCnt <= holdCnt - CNT_W'(1);
    end
    // Ready means a command decided now lands in a legal cycle
    assign ready[b] = loadMask[b] ? (dNow <= CNT_W'(1)) : (holdCnt <= CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasN <= 1'b1; casN <= 1'b1; weN <= 1'b1; a10 <= 1'b0; a11 <= 1'b0;
    end else if (strobe.fireA || strobe.fireB) begin
      rasN <= 1'b0; casN <= 1'b1; weN <= 1'b0;
      a10  <= strobe.fireA && strobe.fireB;
      a11  <= strobe.fireB && !strobe.fireA;
    end else begin
      rasN <= 1'b1; casN <= 1'b1; weN <= 1'b1; a10 <= 1'b0; a11 <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_precharge_ctrl.sv
module bank_precharge_ctrl
  import bank_precharge_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 actValid,
  input  logic                 actBank,
  input  logic                 accValid,
  input  logic                 accBank,
  input  logic                 accAuto,
  input  logic                 preReq,
  input  logic                 preAll,
  input  logic                 preBank,
  input  logic                 pdReq,
  input  logic [NUM_BANKS-1:0] ready,
  output logic [NUM_BANKS-1:0] loadMask,
  output sched_strobe_t        strobe,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 pdGrant
);
  logic [NUM_BANKS-1:0] openQ, pendQ, autoQ;
  logic [NUM_BANKS-1:0] actBit, accBit, reqBit, want, fire, autoAll, autoClose;
  logic live, idle;

  always_comb begin
    live      = !pdGrant;
    actBit    = actValid ? (actBank ? 2'b10 : 2'b01) : 2'b00;
    accBit    = accValid ? (accBank ? 2'b10 : 2'b01) : 2'b00;
    reqBit    = !preReq ? 2'b00 : preAll ? 2'b11 : (preBank ? 2'b10 : 2'b01);
    want      = pendQ | reqBit;
    fire      = live ? (want & ready) : 2'b00;
    autoAll   = autoQ | (accAuto ? accBit : 2'b00);
    autoClose = live ? (autoAll & ready) : 2'b00;
    loadMask  = live ? accBit : 2'b00;
    idle      = (openQ == '0) && (pendQ == '0) && (autoQ == '0) &&
                !actValid && !accValid && !preReq;
    strobe.fireA = fire[0];
    strobe.fireB = fire[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openQ <= '0; pendQ <= '0; autoQ <= '0; pdGrant <= 1'b0;
    end else begin
      if (live) begin
        pendQ <= want & ~fire;
        autoQ <= autoAll & ~ready;
        openQ <= (openQ & ~fire & ~autoClose) | actBit;
      end
      pdGrant <= pdReq && (pdGrant || idle);
    end
  end

  assign bankOpen = openQ;
endmodule

// File: rtl/bank_precharge_sched.sv
module bank_precharge_sched
  import bank_precharge_pkg::*;
#(
  parameter int BL_W = 4,
  parameter int TWR  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            actValid,
  input  logic            actBank,
  input  logic            accValid,
  input  logic            accWrite,
  input  logic            accBank,
  input  logic            accAuto,
  input  logic [1:0]      casLat,
  input  logic [BL_W-1:0] burstLen,
  input  logic            preReq,
  input  logic            preAll,
  input  logic            preBank,
  input  logic            pdReq,
  output logic            rasN,
  output logic            casN,
  output logic            weN,
  output logic            a10,
  output logic            a11,
  output logic [1:0]      bankOpen,
  output logic            pdGrant
);
  logic [NUM_BANKS-1:0] ready, loadMask;
  sched_strobe_t        strobe;

  bank_precharge_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .actValid(actValid), .actBank(actBank),
    .accValid(accValid), .accBank(accBank), .accAuto(accAuto),
    .preReq(preReq), .preAll(preAll), .preBank(preBank), .pdReq(pdReq),
    .ready(ready), .loadMask(loadMask), .strobe(strobe),
    .bankOpen(bankOpen), .pdGrant(pdGrant)
  );

  bank_precharge_dp #(.BL_W(BL_W), .TWR(TWR)) i_dp (
    .clk(clk), .rstN(rstN), .accWrite(accWrite), .accAuto(accAuto),
    .casLat(casLat), .burstLen(burstLen), .loadMask(loadMask),
    .strobe(strobe), .ready(ready),
    .rasN(rasN), .casN(casN), .weN(weN), .a10(a10), .a11(a11)
  );
endmodule

// File: rtl/bank_precharge_checker.sv
module bank_precharge_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pdReq,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       a10,
  input logic       a11,
  input logic [1:0] bankOpen,
  input logic       pdGrant
);
  // The only active command this block drives is a precharge.
  assert_cmd_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> (casN && !weN));

  // Idle cycles carry a NOP with a cleared bank code.
  assert_nop_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    rasN |-> (casN && weN && !a10 && !a11));

  // The targeted bank flag is low while its precharge is on the pins.
  assert_target_closed_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> (a10 ? (bankOpen == 2'b00) : !bankOpen[a11]));

  // Power-down only with all banks closed and quiet pins.
  assert_pd_closed_R10: assert property (@(posedge clk) disable iff (!rstN)
    pdGrant |-> (bankOpen == 2'b00 && rasN));

  assert_pd_entry_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdGrant) |-> $past(pdReq));

  assert_pd_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pdGrant && !pdReq) |=> !pdGrant);

  // State stays frozen during power-down.
  assert_pd_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pdGrant && $past(pdGrant)) |-> $stable(bankOpen));
endmodule

bind bank_precharge_sched bank_precharge_checker i_checker (
  .clk(clk), .rstN(rstN), .pdReq(pdReq), .rasN(rasN), .casN(casN),
  .weN(weN), .a10(a10), .a11(a11), .bankOpen(bankOpen), .pdGrant(pdGrant)
);

// File: tb/test_bank_precharge_sched.sv
module test_bank_precharge_sched;
  localparam int BL_W = 4;
  localparam int TWR  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic actValid = 0, actBank = 0, accValid = 0, accWrite = 0, accBank = 0, accAuto = 0;
  logic [1:0] casLat = 2'd1;
  logic [BL_W-1:0] burstLen = 4'd1;
  logic preReq = 0, preAll = 0, preBank = 0, pdReq = 0;
  logic rasN, casN, weN, a10, a11, pdGrant;
  logic [1:0] bankOpen;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  bank_precharge_sched #(.BL_W(BL_W), .TWR(TWR)) i_bank_precharge_sched (
    .clk(clk), .rstN(rstN), .actValid(actValid), .actBank(actBank),
    .accValid(accValid), .accWrite(accWrite), .accBank(accBank), .accAuto(accAuto),
    .casLat(casLat), .burstLen(burstLen), .preReq(preReq), .preAll(preAll),
    .preBank(preBank), .pdReq(pdReq), .rasN(rasN), .casN(casN), .weN(weN),
    .a10(a10), .a11(a11), .bankOpen(bankOpen), .pdGrant(pdGrant)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected distance from access cycle to precharge start
  function automatic int autoDelay(input bit wr, input int cl, input int bl);
    if (!wr) return bl;
    return (cl == 3) ? bl + 1 : bl;
  endfunction

  function automatic int explDelay(input bit wr, input int cl, input int bl);
    if (!wr) return (cl == 3) ? bl + 1 : bl;
    return bl - 1 + TWR;
  endfunction

  function automatic int maxOf(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  task automatic activate(input bit b);
    @(negedge clk); actValid = 1; actBank = b;
    @(negedge clk); actValid = 0;
    chk(bankOpen[b] == 1'b1, "R3 activate sets flag", int'(bankOpen[b]), 1);
  endtask

  task automatic scenario(input bit wr, input bit b, input bit au, input int cl,
                          input int bl, input int off);
    int t0, rq, got, expc;
    bit quiet;
    activate(b);
    @(negedge clk);
    casLat = 2'(cl); burstLen = BL_W'(bl);
    accValid = 1; accWrite = wr; accBank = b; accAuto = au; t0 = cyc;
    @(negedge clk); accValid = 0;
    if (au) begin
      quiet = 1;
      while (bankOpen[b] && cyc < t0 + 60) begin
        if (!rasN) quiet = 0;
        @(negedge clk);
      end
      got = cyc; expc = t0 + autoDelay(wr, cl, bl);
      if (wr) chk(got == expc, "R5 write auto-precharge start", got - t0, expc - t0);
      else    chk(got == expc, "R4 read auto-precharge start", got - t0, expc - t0);
      chk(quiet && rasN, "R4 auto-precharge drives no pin command", int'(quiet), 1);
    end else begin
      while (cyc < t0 + off) @(negedge clk);
      preReq = 1; preAll = 0; preBank = b; rq = cyc;
      @(negedge clk); preReq = 0;
      while (rasN && cyc < t0 + 60) @(negedge clk);
      got = cyc; expc = maxOf(rq + 1, t0 + explDelay(wr, cl, bl));
      if (wr) chk(got == expc, "R7 write explicit precharge cycle", got - t0, expc - t0);
      else    chk(got == expc, "R6 read explicit precharge cycle", got - t0, expc - t0);
      chk(got == expc, "R8 held request issue cycle", got - rq, expc - rq);
      chk({rasN, casN, weN, a10, a11} == {3'b010, 1'b0, b},
          "R2 single-bank code", int'({rasN, casN, weN, a10, a11}), int'({3'b010, 1'b0, b}));
      chk(bankOpen[b] == 1'b0, "R3 flag low with command", int'(bankOpen[b]), 0);
      @(negedge clk);
      chk(rasN == 1'b1, "R1 NOP after command", int'(rasN), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk({rasN, casN, weN, a10, a11} == 5'b11100, "R1 reset pins NOP",
        int'({rasN, casN, weN, a10, a11}), 5'b11100);
    chk(bankOpen == 2'b00 && !pdGrant, "R1 reset flags", int'({bankOpen, pdGrant}), 0);

    // Directed corners over latencies and lengths
    scenario(0, 0, 1, 2, 4, 1);
    scenario(0, 1, 1, 3, 4, 1);
    scenario(0, 0, 1, 1, 1, 1);
    scenario(1, 1, 1, 2, 4, 1);
    scenario(1, 0, 1, 3, 2, 1);
    scenario(0, 0, 0, 1, 4, 1);
    scenario(0, 1, 0, 3, 4, 1);
    scenario(1, 0, 0, 2, 1, 1);
    scenario(1, 1, 0, 3, 8, 12);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      scenario(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), int'($urandom_range(1, 3)),
               int'($urandom_range(1, 8)), int'($urandom_range(1, 12)));
    end

    // All-banks request
    activate(0); activate(1);
    @(negedge clk); preReq = 1; preAll = 1;
    @(negedge clk); preReq = 0; preAll = 0;
    chk({rasN, casN, weN, a10, a11} == 5'b01010, "R9 all-banks command",
        int'({rasN, casN, weN, a10, a11}), 5'b01010);
    chk(bankOpen == 2'b00, "R9 all banks closed", int'(bankOpen), 0);

    // Request to a closed bank
    @(negedge clk); preReq = 1; preBank = 1;
    @(negedge clk); preReq = 0;
    chk({rasN, casN, weN, a10, a11} == 5'b01001, "R9 closed-bank request accepted",
        int'({rasN, casN, weN, a10, a11}), 5'b01001);

    // Power-down entry, ignored inputs, exit
    @(negedge clk); pdReq = 1;
    @(negedge clk);
    chk(pdGrant == 1'b1, "R10 entry one cycle after request", int'(pdGrant), 1);
    actValid = 1; actBank = 0; preReq = 1; preBank = 1;
    @(negedge clk); actValid = 0; preReq = 0;
    chk(rasN == 1'b1 && bankOpen == 2'b00, "R11 inputs ignored in power-down",
        int'({rasN, bankOpen}), 4);
    pdReq = 0;
    @(negedge clk);
    chk(pdGrant == 1'b0, "R10 exit one cycle after release", int'(pdGrant), 0);
    chk(bankOpen == 2'b00 && rasN, "R11 no trace after exit", int'({rasN, bankOpen}), 4);

    // Refused while a bank is open
    activate(0);
    pdReq = 1;
    repeat (3) @(negedge clk);
    chk(pdGrant == 1'b0, "R10 refused with open bank", int'(pdGrant), 0);
    preReq = 1; preBank = 0;
    @(negedge clk); preReq = 0;
    chk(pdGrant == 1'b0 && !rasN, "R10 no grant in precharge cycle", int'(pdGrant), 0);
    @(negedge clk);
    chk(pdGrant == 1'b1, "R10 grant once closed", int'(pdGrant), 1);
    pdReq = 0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule